// File: doc/BRIEF.md
# Link isolation recovery controller

This block decides when a misbehaving master on the host link must be cut off from the on-chip fabric, and then walks the fabric through a fixed recovery sequence before letting the master back in. Six trigger sources feed it: link down, function-level reset, secondary bus reset, monitor AXI timeout, no-target AXI timeout and a PIR event. Each source has its own enable. A source only counts while its enable is set.

A qualified trigger must persist for a programmable number of cycles before isolation starts. A count of zero isolates on the first sampled cycle. While isolated, the block holds an isolate output that the fabric uses to refuse new transactions and answer with error responses. It then pulses the AW, W and AR staging-FIFO resets in that order, then the fabric reset, then a clear-errors strobe. It then waits for a reset-done acknowledge from management firmware. In automatic mode each phase lasts one cycle. In manual mode firmware advances every phase from isolation through the fabric reset with a step input. Entry and exit are reported as one-cycle event bits next to the latched causes in a 16-bit interrupt event word.

Top module: `link_iso_recovery`

## Requirements
- R1: Trigger input bit i (0 link down, 1 FLR, 2 SBR, 3 monitor AXI timeout, 4 no-target AXI timeout, 5 PIR) appears in event word bit 8+i. The cause bits hold the enabled triggers that were active when isolation began and stay set until the clear-errors phase.
- R2: A trigger whose enable bit is 0 has no effect: isolate stays low and the event word stays zero.
- R3: With debounce count D, a qualified trigger held continuously raises isolate_o after D+1 rising edges, counting the edge that first samples it. With D = 0 this is a single edge.
- R4: If every qualified trigger drops during the debounce phase, the controller returns to normal without isolating. The next trigger waits the full D again.
- R5: Teardown order is fixed: isolate first, then fifo_rst_o[0] (AW), fifo_rst_o[1] (W), fifo_rst_o[2] (AR), then fabric_rst_o, then clear_err_o. Only one of these outputs is active at a time.
- R6: With auto_step_i = 1, the isolated phase and each of the five teardown phases lasts exactly one cycle.
- R7: With auto_step_i = 0, the isolated, AW, W, AR and fabric-reset phases advance only on a cycle where step_i is 1. The clear-errors phase always lasts one cycle.
- R8: After clear-errors, isolate_o stays high until reset_done_i is 1. reset_done_i is ignored in every other phase.
- R9: Event bit 14 is a one-cycle pulse in the first isolated cycle. Event bit 15 is a one-cycle pulse in the first cycle after exit. Cause bits read zero once clear-errors has completed.
- R10: An enabled trigger seen during recovery is held pending. After exit it restarts debounce and isolation even if the source has gone, and it becomes the cause of the new episode.
- R11: isolate_o is high in every recovery phase, including all reset strobes. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | NUM_SRC | Level trigger sources, bit order as in R1 |
| trig_en_i | input | NUM_SRC | Per-source enable |
| debounce_i | input | CNT_W | Debounce count, 0 = isolate at once |
| auto_step_i | input | 1 | 1 = phases advance by themselves |
| step_i | input | 1 | Firmware advance for manual mode |
| reset_done_i | input | 1 | Firmware acknowledge that allows exit |
| isolate_o | output | 1 | Fabric must refuse new transactions and return errors |
| fifo_rst_o | output | 3 | Staging FIFO resets: [0] AW, [1] W, [2] AR |
| fabric_rst_o | output | 1 | Fabric reset strobe |
| clear_err_o | output | 1 | Clear sticky error causes strobe |
| irq_evt_o | output | 16 | [13:8] causes, [14] enter, [15] exit, [7:0] zero |

## Verification
Assertions check the per-cycle rules on every cycle. These are the AW, W, AR, fabric, clear ordering, isolation covering every reset strobe, the single-cycle event pulses, phases holding without a step in manual mode, the wait for acknowledge, and a pending trigger forcing a restart. Debounce latency for a given count, the full reload after an aborted debounce, the cause encoding per source, and the fact that disabled sources leave every output untouched are end-to-end timing and value properties. Only the bench scenarios can show them, by measuring edges from stimulus to isolate_o and reading the event word.

// File: rtl/liso_pkg.sv
package liso_pkg;
   localparam int MAX_SRC       = 6;
   localparam int FIFO_LANES    = 3;
   localparam int EVT_W         = 16;
   localparam int EVT_CAUSE_LSB = 8;
   localparam int EVT_ENTER_BIT = 14;
   localparam int EVT_EXIT_BIT  = 15;

   typedef enum logic [3:0] {
      PH_NORMAL,
      PH_DEBOUNCE,
      PH_ISOLATED,
      PH_DRAIN_AW,
      PH_DRAIN_W,
      PH_DRAIN_AR,
      PH_FABRIC,
      PH_CLEAR,
      PH_WAIT_ACK
   } phase_e;

   function automatic logic in_recovery(phase_e p);
      return (p != PH_NORMAL) && (p != PH_DEBOUNCE);
   endfunction
endpackage

// File: rtl/liso_trig_qual.sv
module liso_trig_qual #(
   parameter int NUM_SRC     = 6,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic [NUM_SRC-1:0] qual_o
);
   logic [NUM_SRC-1:0] sync_w;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sync_w = trig_i;
   end else begin : g_sync
      logic [NUM_SRC-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= trig_i;
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign sync_w = stg_q[SYNC_STAGES-1];
   end

   assign qual_o = sync_w & en_i;
endmodule

// File: rtl/liso_debounce.sv
module liso_debounce #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt_q <= '0;
      else if (load_i)                         cnt_q <= val_i;
      else if (run_i && cnt_q > CNT_W'(1))     cnt_q <= cnt_q - CNT_W'(1);
   end

   assign done_o = (cnt_q == CNT_W'(1));

   // debounce phase is only ever entered with a nonzero count loaded
   assert_run_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q != '0));
endmodule

// File: rtl/liso_seq.sv
module liso_seq
   import liso_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go_i,
   input  logic   deb_zero_i,
   input  logic   deb_done_i,
   input  logic   auto_i,
   input  logic   step_i,
   input  logic   ack_i,
   output phase_e phase_o,
   output logic   enter_o,
   output logic   exit_o
);
   phase_e cur_q, nxt;
   logic   adv;

   assign adv = auto_i | step_i;

   always_comb begin
      nxt = cur_q;
      unique case (cur_q)
         PH_NORMAL:   if (go_i) nxt = deb_zero_i ? PH_ISOLATED : PH_DEBOUNCE;
         PH_DEBOUNCE: if (!go_i) nxt = PH_NORMAL;
                      else if (deb_done_i) nxt = PH_ISOLATED;
         PH_ISOLATED: if (adv) nxt = PH_DRAIN_AW;
         PH_DRAIN_AW: if (adv) nxt = PH_DRAIN_W;
         PH_DRAIN_W:  if (adv) nxt = PH_DRAIN_AR;
         PH_DRAIN_AR: if (adv) nxt = PH_FABRIC;
         PH_FABRIC:   if (adv) nxt = PH_CLEAR;
         PH_CLEAR:    nxt = PH_WAIT_ACK;
         PH_WAIT_ACK: if (ack_i) nxt = PH_NORMAL;
         default:     nxt = PH_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= PH_NORMAL;
      else        cur_q <= nxt;
   end

   assign phase_o = cur_q;
   assign enter_o = !in_recovery(cur_q) && (nxt == PH_ISOLATED);
   assign exit_o  = (cur_q == PH_WAIT_ACK) && ack_i;

   assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_i && !step_i && (cur_q inside {PH_ISOLATED, PH_DRAIN_AW, PH_DRAIN_W,
                                            PH_DRAIN_AR, PH_FABRIC}))
      |=> (cur_q == $past(cur_q)));

   assert_wait_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == PH_WAIT_ACK && !ack_i) |=> (cur_q == PH_WAIT_ACK));
endmodule

// File: rtl/link_iso_recovery.sv
module link_iso_recovery
   import liso_pkg::*;
#(
   parameter int NUM_SRC     = 6,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    trig_i,
   input  logic [NUM_SRC-1:0]    trig_en_i,
   input  logic [CNT_W-1:0]      debounce_i,
   input  logic                  auto_step_i,
   input  logic                  step_i,
   input  logic                  reset_done_i,
   output logic                  isolate_o,
   output logic [FIFO_LANES-1:0] fifo_rst_o,
   output logic                  fabric_rst_o,
   output logic                  clear_err_o,
   output logic [EVT_W-1:0]      irq_evt_o
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("link_iso_recovery: NUM_SRC must be 1..6");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("link_iso_recovery: CNT_W must be 1..32");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("link_iso_recovery: SYNC_STAGES must be 0..4");
   end

   logic [NUM_SRC-1:0] qual;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] cause_q;
   logic [MAX_SRC-1:0] cause_pad;
   logic               go, deb_zero, deb_done, deb_load, deb_run;
   logic               enter, leave, enter_q, exit_q;
   phase_e             phase;

   liso_trig_qual #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .en_i(trig_en_i), .qual_o(qual));

   assign go       = (|qual) | (|pend_q);
   assign deb_zero = (debounce_i == '0);
   assign deb_load = (phase == PH_NORMAL) && go && !deb_zero;
   assign deb_run  = (phase == PH_DEBOUNCE) && go;

   liso_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk(clk), .rst_n(rst_n), .load_i(deb_load), .run_i(deb_run),
      .val_i(debounce_i), .done_o(deb_done));

   liso_seq u_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go), .deb_zero_i(deb_zero),
      .deb_done_i(deb_done), .auto_i(auto_step_i), .step_i(step_i),
      .ack_i(reset_done_i), .phase_o(phase), .enter_o(enter), .exit_o(leave));

   // causes latch on entry, pending collects triggers seen during recovery
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         pend_q  <= '0;
         enter_q <= 1'b0;
         exit_q  <= 1'b0;
      end else begin
         enter_q <= enter;
         exit_q  <= leave;
         if (enter) begin
            cause_q <= qual | pend_q;
            pend_q  <= '0;
         end else begin
            if (phase == PH_CLEAR) cause_q <= '0;
            if (in_recovery(phase)) pend_q <= pend_q | qual;
         end
      end
   end

   for (genvar i = 0; i < MAX_SRC; i++) begin : g_pad
      if (i < NUM_SRC) begin : g_used
         assign cause_pad[i] = cause_q[i];
      end else begin : g_zero
         assign cause_pad[i] = 1'b0;
      end
   end

   assign isolate_o     = in_recovery(phase);
   assign fifo_rst_o[0] = (phase == PH_DRAIN_AW);
   assign fifo_rst_o[1] = (phase == PH_DRAIN_W);
   assign fifo_rst_o[2] = (phase == PH_DRAIN_AR);
   assign fabric_rst_o  = (phase == PH_FABRIC);
   assign clear_err_o   = (phase == PH_CLEAR);
   assign irq_evt_o     = {exit_q, enter_q, cause_pad, EVT_CAUSE_LSB'(0)};

   assert_aw_after_iso_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_rst_o[0]) |-> $past(isolate_o));
   assert_w_after_aw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_rst_o[1]) |-> $past(fifo_rst_o[0]));
   assert_ar_after_w_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_rst_o[2]) |-> $past(fifo_rst_o[1]));
   assert_fab_after_ar_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fabric_rst_o) |-> $past(fifo_rst_o[2]));
   assert_clr_after_fab_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clear_err_o) |-> $past(fabric_rst_o));
   assert_strobes_isolated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fifo_rst_o) || fabric_rst_o || clear_err_o) |-> isolate_o);
   assert_cause_on_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isolate_o) |-> (cause_q != '0));
   assert_enter_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt_o[EVT_ENTER_BIT] |=> !irq_evt_o[EVT_ENTER_BIT]);
   assert_exit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt_o[EVT_EXIT_BIT] |=> !irq_evt_o[EVT_EXIT_BIT]);
   assert_cause_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear_err_o |=> (cause_q == '0));
   assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_NORMAL && qual == '0 && pend_q == '0) |=> !isolate_o);
   assert_pend_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_NORMAL && pend_q != '0) |=> (phase != PH_NORMAL));
endmodule

// File: tb/tb_link_iso_recovery.sv
`timescale 1ns/1ps
module tb_link_iso_recovery;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  trig_i = '0;
   logic [5:0]  trig_en_i = '0;
   logic [15:0] debounce_i = '0;
   logic        auto_step_i = 1'b1;
   logic        step_i = 1'b0;
   logic        reset_done_i = 1'b0;
   logic        isolate_o;
   logic [2:0]  fifo_rst_o;
   logic        fabric_rst_o;
   logic        clear_err_o;
   logic [15:0] irq_evt_o;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   link_iso_recovery dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .trig_en_i(trig_en_i),
      .debounce_i(debounce_i), .auto_step_i(auto_step_i), .step_i(step_i),
      .reset_done_i(reset_done_i), .isolate_o(isolate_o), .fifo_rst_o(fifo_rst_o),
      .fabric_rst_o(fabric_rst_o), .clear_err_o(clear_err_o), .irq_evt_o(irq_evt_o));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // expected latency in edges for debounce count d
   function automatic int exp_lat(input int d);
      return d + 1;
   endfunction

   // {iso, aw, w, ar, fab, clr} for recovery phase index p (0 iso .. 6 wait ack)
   function automatic int exp_out(input int p);
      int v;
      v = 32;
      if (p == 1) v |= 16;
      if (p == 2) v |= 8;
      if (p == 3) v |= 4;
      if (p == 4) v |= 2;
      if (p == 5) v |= 1;
      return v;
   endfunction

   function automatic int obs_out();
      return int'({isolate_o, fifo_rst_o[0], fifo_rst_o[1], fifo_rst_o[2],
                   fabric_rst_o, clear_err_o});
   endfunction

   task automatic wait_iso(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (!isolate_o && n < 200);
   endtask

   // walks a full recovery starting in the first isolated cycle
   task automatic recover(input bit autom, input int pend_src, input int exp_cause);
      int p;
      bit first;
      chk("R9", "enter event bit", int'(irq_evt_o[14]), 1);
      chk("R1", "cause bits at entry", int'(irq_evt_o[13:8]), exp_cause);
      trig_i = '0;
      auto_step_i = autom;
      p = 0;
      first = 1'b1;
      while (p < 6) begin
         bit s;
         s = 1'($urandom_range(0, 1));
         step_i = s;
         reset_done_i = 1'($urandom_range(0, 1));
         if (pend_src >= 0 && p == 2) trig_i[pend_src] = 1'b1;
         tick();
         trig_i = '0;
         if (autom || s || p == 5) p++;
         chk(autom ? "R6" : "R7", "phase outputs", obs_out(), exp_out(p));
         if (first) chk("R9", "enter pulse ends", int'(irq_evt_o[14]), 0);
         first = 1'b0;
      end
      step_i = 1'b0;
      reset_done_i = 1'b0;
      repeat ($urandom_range(0, 3)) begin
         step_i = 1'($urandom_range(0, 1));
         tick();
         chk("R8", "held until ack", obs_out(), exp_out(6));
      end
      step_i = 1'b0;
      chk("R9", "causes cleared", int'(irq_evt_o[13:8]), 0);
      reset_done_i = 1'b1;
      tick();
      reset_done_i = 1'b0;
      chk("R8", "isolate after ack", int'(isolate_o), 0);
      chk("R9", "exit event bit", int'(irq_evt_o[15]), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL all watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // reset state
      chk("R11", "reset phase outputs", obs_out(), 0);
      chk("R11", "reset event word", int'(irq_evt_o), 0);

      // R2: disabled source ignored
      trig_en_i = 6'b111110;
      trig_i = 6'b000001;
      repeat (8) begin
         tick();
         chk("R2", "disabled isolate", int'(isolate_o), 0);
         chk("R2", "disabled events", int'(irq_evt_o), 0);
      end
      trig_i = '0;
      trig_en_i = 6'b111111;
      tick();

      // R3: zero count isolates on first edge
      debounce_i = 16'd0;
      trig_i = 6'b001000;
      wait_iso(n);
      chk("R3", "latency D=0", n, exp_lat(0));
      recover(1'b1, -1, 6'b001000);
      tick();
      chk("R9", "exit pulse ends", int'(irq_evt_o[15]), 0);

      // R4: abort during debounce then full reload
      debounce_i = 16'd4;
      trig_i = 6'b000010;
      repeat (3) begin
         tick();
         chk("R4", "no isolate while debouncing", int'(isolate_o), 0);
      end
      trig_i = '0;
      repeat (3) begin
         tick();
         chk("R4", "aborted debounce", int'(isolate_o), 0);
      end
      trig_i = 6'b000010;
      wait_iso(n);
      chk("R4", "reloaded latency", n, exp_lat(4));
      recover(1'b1, -1, 6'b000010);
      tick();

      // R7: manual stepping, PIR source (bit 5)
      debounce_i = 16'd2;
      trig_i = 6'b100000;
      wait_iso(n);
      chk("R3", "latency D=2", n, exp_lat(2));
      recover(1'b0, -1, 6'b100000);
      tick();

      // R10: pending trigger during recovery restarts
      debounce_i = 16'd1;
      trig_i = 6'b000100;
      wait_iso(n);
      chk("R3", "latency D=1", n, exp_lat(1));
      recover(1'b1, 4, 6'b000100);
      wait_iso(n);
      chk("R10", "pending restart latency", n, exp_lat(1));
      recover(1'b1, -1, 6'b010000);
      tick();

      // random scenarios
      for (int it = 0; it < 30; it++) begin
         int d, src, ps;
         logic [5:0] en, tr;
         d   = $urandom_range(0, 6);
         src = $urandom_range(0, 5);
         en  = 6'($urandom) | 6'(1 << src);
         tr  = 6'($urandom) | 6'(1 << src);
         ps  = ($urandom_range(0, 3) == 0) ? src : -1;
         debounce_i = 16'(d);
         trig_en_i = en;
         trig_i = tr;
         wait_iso(n);
         chk("R3", "random latency", n, exp_lat(d));
         recover(1'($urandom_range(0, 1)), ps, int'(tr & en));
         if (ps >= 0) begin
            wait_iso(n);
            chk("R10", "random pending restart", n, exp_lat(d));
            recover(1'b1, -1, 1 << src);
         end
         tick();
         chk("R9", "random exit pulse ends", int'(irq_evt_o[15]), 0);
         chk("R11", "random idle", obs_out(), 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule